// File: doc/BRIEF.md
# SIMD GF(2^8) Byte Affine Unit

This block applies an affine map over GF(2^8) to every byte of a packed vector. Each 64-bit lane of the matrix operand holds an 8x8 bit matrix. That matrix is multiplied with each of the eight data bytes in the same lane of the data operand. An 8-bit constant, shared by the whole vector, is then added with XOR. Units like this are used for S-box style byte substitutions and bit permutations.

The vector width is chosen on each operation: 128, 256 or 512 bits. The unit supports per-byte write masking, where a masked-off byte is either merged from a supplied previous value or forced to zero. It can also broadcast the matrix in lane 0 to every lane.

Inputs are taken on a valid strobe. The masked result is registered and presented one clock later with its own valid flag.

Top module: `gfa_affine_unit`

## Requirements
- R1: Result bit i of a byte is the XOR of two terms. The first is the parity of the matrix byte at position 7-i of the lane's 64-bit matrix (byte k is bits 8k+7..8k), ANDed with the data byte. The second is bit i of `constB`.
- R2: Without broadcast, lane j of `matVec` (bits 64j+63..64j) is the matrix for the eight data bytes in lane j of `xVec`.
- R3: The single `constB` value is added to every byte of the vector.
- R4: With `bcast` high, lane 0 of `matVec` is the matrix for every lane, and the other lanes of `matVec` have no effect on the result.
- R5: A byte takes the computed value when `maskEn` is low, or when its mask bit is set. Byte b of lane j uses mask bit 8j+b.
- R6: With `maskEn` high and `zeroMode` high, a byte whose mask bit is clear becomes 0x00.
- R7: With `maskEn` high and `zeroMode` low, a byte whose mask bit is clear takes the same byte of `prevDst`.
- R8: `widthSel` encodes the active width: 0 = 128 bits (2 lanes), 1 = 256 bits (4 lanes), 2 or 3 = 512 bits (8 lanes). All result bits above the active width are zero.
- R9: The result and `outValid` appear on the clock edge after the one on which `inValid` is sampled high. `outValid` is low after a cycle without `inValid`, and the result holds its value until the next accepted operation.
- R10: Synchronous active-high reset clears `outValid` and the whole result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Capture strobe for all operands |
| xVec | input | 512 | Data bytes |
| matVec | input | 512 | One 8x8 matrix per 64-bit lane |
| constB | input | 8 | Additive constant |
| maskBits | input | 64 | Per-byte write mask |
| maskEn | input | 1 | Enable masking |
| zeroMode | input | 1 | Masked-off bytes become zero rather than merged |
| bcast | input | 1 | Use lane 0 matrix for all lanes |
| widthSel | input | 2 | Active vector width select |
| prevDst | input | 512 | Previous destination, for merge |
| outValid | output | 1 | Result valid |
| result | output | 512 | Registered result |

## Verification
The assertions assume the following about the inputs:
- Reset is high from the very first clock edge.
- Every operand is at a known value on each cycle where `inValid` is high, because the zeroing, merging and width-clearing properties compare the registered result against operands sampled on that edge.

The bench keeps to these conditions. It holds reset from time zero and drives every input to a defined value on the falling edge, well clear of the capture edge. Operand values come from a deterministic generator, not from undriven lines.

// File: rtl/gfa_pkg.sv
package gfa_pkg;

  typedef struct packed {
    logic load;
    logic clear;
  } gfaStrobe_t;

  // One byte of the affine map: row for output bit i is matrix byte 7-i.
  function automatic logic [7:0] affineByte(input logic [63:0] mat,
                                            input logic [7:0]  x,
                                            input logic [7:0]  b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      r[i] = (^(mat[(7-i)*8 +: 8] & x)) ^ b[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/gfa_ctrl.sv
module gfa_ctrl
  import gfa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output gfaStrobe_t strb,
  output logic       outValid
);

  always_comb begin
    strb.clear = rst;
    strb.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= strb.load;
  end

endmodule

// File: rtl/gfa_datapath.sv
module gfa_datapath
  import gfa_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  gfaStrobe_t            strb,
  input  logic [LANES*64-1:0]   xVec,
  input  logic [LANES*64-1:0]   matVec,
  input  logic [7:0]            constB,
  input  logic [LANES*8-1:0]    maskBits,
  input  logic                  maskEn,
  input  logic                  zeroMode,
  input  logic                  bcast,
  input  logic [1:0]            widthSel,
  input  logic [LANES*64-1:0]   prevDst,
  output logic [LANES*64-1:0]   resQ
);

  localparam int W = LANES * 64;

  logic [1:0]       wsEff;
  logic [LANES-1:0] laneOn;
  logic [W-1:0]     nxt;

  assign wsEff = (widthSel == 2'd3) ? 2'd2 : widthSel;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [63:0] laneMat;
    assign laneMat   = bcast ? matVec[63:0] : matVec[j*64 +: 64];
    assign laneOn[j] = (32'(j) < (32'd2 << wsEff));

    for (genvar b = 0; b < 8; b++) begin : g_byte
      localparam int IDX = j*8 + b;
      logic [7:0] comp;
      assign comp = affineByte(laneMat, xVec[IDX*8 +: 8], constB);
      assign nxt[IDX*8 +: 8] =
        !laneOn[j]                 ? 8'h00 :
        (!maskEn || maskBits[IDX]) ? comp  :
        zeroMode                   ? 8'h00 : prevDst[IDX*8 +: 8];
    end

    // R8
    lane_off_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (strb.load && !laneOn[j]) |=> (resQ[j*64 +: 64] == 64'h0));
  end

  always_ff @(posedge clk) begin
    if (strb.clear)     resQ <= '0;
    else if (strb.load) resQ <= nxt;
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(resQ));

  // R6
  zero_all_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.load && maskEn && zeroMode && (maskBits == '0)) |=> (resQ == '0));

  // R7
  merge_all_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.load && maskEn && !zeroMode && (maskBits == '0) && (&laneOn))
      |=> (resQ == $past(prevDst)));

endmodule

// File: rtl/gfa_affine_unit.sv
module gfa_affine_unit
  import gfa_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [LANES*64-1:0]  xVec,
  input  logic [LANES*64-1:0]  matVec,
  input  logic [7:0]           constB,
  input  logic [LANES*8-1:0]   maskBits,
  input  logic                 maskEn,
  input  logic                 zeroMode,
  input  logic                 bcast,
  input  logic [1:0]           widthSel,
  input  logic [LANES*64-1:0]  prevDst,
  output logic                 outValid,
  output logic [LANES*64-1:0]  result
);

  gfaStrobe_t strb;

  gfa_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strb     (strb),
    .outValid (outValid)
  );

  gfa_datapath #(.LANES(LANES)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .xVec     (xVec),
    .matVec   (matVec),
    .constB   (constB),
    .maskBits (maskBits),
    .maskEn   (maskEn),
    .zeroMode (zeroMode),
    .bcast    (bcast),
    .widthSel (widthSel),
    .prevDst  (prevDst),
    .resQ     (result)
  );

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

endmodule

// File: tb/gfa_affine_unit_tb.sv
module gfa_affine_unit_tb;

  localparam int LANES = 8;
  localparam int W = LANES * 64;
  localparam logic [63:0] IDENT = 64'h0102040810204080;

  // flags[7:0] = {2'b0, widthSel[1:0], ident, bcast, zeroMode, maskEn}
  localparam logic [47:0] VECS [12] = '{
    {8'h2C, 8'h00, 32'h0000_1234},  // identity, 512, pass-through (R1)
    {8'h0C, 8'h00, 32'h0000_9876},  // identity, 128 (R8)
    {8'h20, 8'h00, 32'hDEAD_0001},  // random matrices per lane (R2)
    {8'h20, 8'h5A, 32'hBEEF_0002},  // constant (R3)
    {8'h24, 8'hC3, 32'h0BAD_0003},  // broadcast (R4)
    {8'h21, 8'h11, 32'h1111_0004},  // merge mask (R5 R7)
    {8'h23, 8'h22, 32'h2222_0005},  // zero mask (R6)
    {8'h11, 8'h33, 32'h3333_0006},  // 256, merge (R8)
    {8'h07, 8'h44, 32'h4444_0007},  // 128, bcast, zero (R8)
    {8'h30, 8'h55, 32'h5555_0008},  // sel 3 = 512 (R8)
    {8'h2D, 8'hFF, 32'h6666_0009},  // identity, merge, const
    {8'h16, 8'h0F, 32'h7777_000A}   // 256, bcast, zeroMode w/o maskEn (R5)
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [W-1:0] xVec = '0, matVec = '0, prevDst = '0;
  logic [7:0] constB = '0;
  logic [LANES*8-1:0] maskBits = '0;
  logic maskEn = 1'b0, zeroMode = 1'b0, bcast = 1'b0;
  logic [1:0] widthSel = 2'd2;
  logic outValid;
  logic [W-1:0] result;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gfa_affine_unit #(.LANES(LANES)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .xVec(xVec), .matVec(matVec),
    .constB(constB), .maskBits(maskBits), .maskEn(maskEn), .zeroMode(zeroMode),
    .bcast(bcast), .widthSel(widthSel), .prevDst(prevDst),
    .outValid(outValid), .result(result)
  );

  function automatic logic [63:0] xs(input logic [63:0] s);
    logic [63:0] t;
    t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  function automatic logic [W-1:0] model(
      input logic [W-1:0] x, input logic [W-1:0] m, input logic [7:0] b,
      input logic [LANES*8-1:0] mk, input logic en, input logic zm,
      input logic bc, input logic [1:0] ws, input logic [W-1:0] pv);
    logic [W-1:0] r;
    int lanes;
    r = '0;
    lanes = (ws == 2'd0) ? 2 : (ws == 2'd1) ? 4 : 8;
    for (int j = 0; j < lanes; j++) begin
      for (int k = 0; k < 8; k++) begin
        logic [63:0] mat;
        logic [7:0] xb, v;
        int n;
        mat = bc ? m[63:0] : m[j*64 +: 64];
        xb = x[(j*8+k)*8 +: 8];
        for (int i = 0; i < 8; i++) begin
          n = 0;
          for (int q = 0; q < 8; q++)
            if (mat[(7-i)*8 + q] && xb[q]) n++;
          v[i] = (n % 2 == 1) ^ b[i];
        end
        if (en && !mk[j*8+k]) v = zm ? 8'h00 : pv[(j*8+k)*8 +: 8];
        r[(j*8+k)*8 +: 8] = v;
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) inValid = 1'b1;
    @(negedge clk) inValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset outValid", W'(outValid), '0);
    chk("R10 reset result", result, '0);
    rst = 1'b0;

    for (int e = 0; e < 12; e++) begin
      logic [63:0] s;
      logic [W-1:0] exp;
      logic [7:0] f;
      f = VECS[e][47:40];
      s = {32'hA5A5_0000 ^ 32'(e), VECS[e][31:0]} | 64'h1;
      @(negedge clk);
      for (int j = 0; j < LANES; j++) begin
        s = xs(s); xVec[j*64 +: 64] = s;
        s = xs(s); matVec[j*64 +: 64] = f[3] ? IDENT : s;
        s = xs(s); prevDst[j*64 +: 64] = s;
        s = xs(s); maskBits[j*8 +: 8] = s[7:0];
      end
      constB = VECS[e][39:32];
      maskEn = f[0]; zeroMode = f[1]; bcast = f[2]; widthSel = f[5:4];
      inValid = 1'b1;
      exp = model(xVec, matVec, constB, maskBits, maskEn, zeroMode, bcast, widthSel, prevDst);
      @(negedge clk) inValid = 1'b0;
      chk("R9 outValid", W'(outValid), W'(1));
      chk($sformatf("R1 R2 R3 R4 R5 R6 R7 R8 vector %0d", e), result, exp);
      if (e == 0) chk("R1 identity pass-through", result, xVec);
    end

    // R1 hand value: only matrix byte 7 set, x=0x07, b=0x10 -> 0x11 in every byte
    matVec = '0; matVec[63:56] = 8'hFF; xVec = {64{8'h07}};
    constB = 8'h10; maskEn = 0; bcast = 1; widthSel = 2'd2;
    pulse();
    chk("R1 R4 hand value", result, {64{8'h11}});

    // R9 hold: change inputs without inValid
    xVec = '1; constB = 8'h99;
    @(negedge clk); @(negedge clk);
    chk("R9 outValid low", W'(outValid), '0);
    chk("R9 result held", result, {64{8'h11}});

    // R7 full merge
    maskEn = 1; zeroMode = 0; maskBits = '0; prevDst = {8{64'h0123_4567_89AB_CDEF}};
    pulse();
    chk("R7 full merge", result, prevDst);

    // R6 full zero
    zeroMode = 1;
    pulse();
    chk("R6 full zero", result, '0);

    // R10 reset mid-run
    maskEn = 0;
    pulse();
    @(negedge clk) begin rst = 1'b1; inValid = 1'b1; end
    @(negedge clk) begin rst = 1'b0; inValid = 1'b0; end
    chk("R10 reset outValid mid-run", W'(outValid), '0);
    chk("R10 reset result mid-run", result, '0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule